// File: doc/BRIEF.md
# Timed Packet Delay Queue

This block stands in for one network link inside a hardware network simulator. Each packet arrives as a 72-bit descriptor with the timestamp at which it was injected and its size. The block works out a release time for it: the injection timestamp, plus a configured base latency, plus a bandwidth term equal to the size divided by a configured rate. The bandwidth term comes from a 12-bit divider pipelined over four clock cycles. The descriptor and its release time are then stored in a 64-entry first-in first-out buffer.

The entry at the head of the buffer is offered on the dequeue side once the simulated time has reached its release time. Simulated time is a 16-bit counter that wraps, so the block compares times by modular subtraction. A packet can leave later than its release time. When the head is due and its lateness goes past a configured limit, the block raises a stall output. A global time controller uses that output to stop advancing simulated time.

The in-flight and stored packets share one budget of 64 slots. An enqueue that arrives when all 64 slots are taken is discarded (drop-tail), so no packet is ever lost between the divider and storage.

Top module: `link_delay_queue`

## Requirements
- R1: After reset the queue is empty: `deqValid` and `tooLate` are low.
- R2: The release time is computed as `(enqStamp + cfgBaseLatency + floor(enqSize / cfgRate)) mod 2^16`, using the `enqSize`, `cfgRate` and `cfgBaseLatency` values present in the accepting cycle. It appears on `headRelease` when that packet is at the head.
- R3: A packet accepted at clock edge E is written to storage at edge E+4. A head entry that is already due shows `deqValid` high after E+4 and not before.
- R4: Packets leave in the order they were accepted, and only the head is tested for release. A later packet whose release time has passed waits behind a head that is not yet due.
- R5: The count of stored packets plus in-flight packets never exceeds 64. An enqueue made when that count is 64 is discarded, and the packets already held are delivered intact.
- R6: `tooLate` is high exactly when `deqValid` is high and `(simTime - headRelease) mod 2^16` is greater than `cfgLateLimit`. It stays low when the lateness equals the limit.
- R7: A head is due when `(simTime - headRelease) mod 2^16` is below 2^15. The comparison is therefore correct across the wrap of `simTime`, for example release 0x0008 against time 0xFFF8 (not due) and 0x0008 (due).
- R8: A rate of zero gives a bandwidth term of 0xFFF.
- R9: The head entry is removed only on a cycle where `deqValid` and `deqReady` are both high. `deqReady` while the head is not due leaves the head unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Offer a packet this cycle |
| enqDesc | input | 72 | Packet descriptor |
| enqStamp | input | 16 | Injection timestamp |
| enqSize | input | 12 | Packet size (dividend) |
| cfgRate | input | 12 | Link rate (divisor) |
| cfgBaseLatency | input | 16 | Fixed part of the link delay |
| cfgLateLimit | input | 16 | Allowed lateness before stalling time |
| simTime | input | 16 | Current simulated time, wrapping |
| deqReady | input | 1 | Consumer takes the head this cycle |
| deqValid | output | 1 | Head entry is due |
| deqDesc | output | 72 | Descriptor at the head |
| headRelease | output | 16 | Release time of the head entry |
| tooLate | output | 1 | Head is later than the limit; stall time |

## Verification
The assertions assume that reset is held long enough for the four divider stages to fill with defined operands, and that `enqValid` is low during reset. They also assume that simulated time never runs more than 2^15 steps ahead of a held release time. The bench keeps the operands driven from time zero and holds reset for several cycles. It keeps every latency at least 3 and moves `simTime` only in small jumps around each release. Its stress sequence fills the queue while all release times lie in the future, so neither the fill limit nor the lateness logic is reached through time running away.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
  typedef struct packed {
    logic launch;
    logic store;
    logic pop;
  } ldqStrobes_t;
endpackage

// File: rtl/ldq_divider.sv
module ldq_divider #(
  parameter int W      = 12,
  parameter int STAGES = 4,
  parameter int SIDE_W = 88
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [W-1:0]      dividend,
  input  logic [W-1:0]      divisor,
  input  logic [SIDE_W-1:0] sideIn,
  output logic [W-1:0]      quotient,
  output logic [SIDE_W-1:0] sideOut
);
  localparam int STEP = W / STAGES;

  // Restoring division: STEP quotient bits per stage.
  function automatic logic [2*W-1:0] divStep(input logic [W-1:0] remIn,
                                             input logic [W-1:0] accIn,
                                             input logic [W-1:0] dvs);
    logic [W-1:0] r;
    logic [W-1:0] a;
    logic [W:0]   trial;
    r = remIn;
    a = accIn;
    for (int b = 0; b < STEP; b++) begin
      trial = {r, a[W-1]};
      a = a << 1;
      if (trial >= {1'b0, dvs}) begin
        trial = trial - {1'b0, dvs};
        a[0]  = 1'b1;
      end
      r = trial[W-1:0];
    end
    return {r, a};
  endfunction

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0]      remIn, accIn, dvsIn;
    logic [SIDE_W-1:0] sideStage;
    logic [W-1:0]      remQ, accQ, dvsQ;
    logic [SIDE_W-1:0] sideQ;
    if (s == 0) begin : g_first
      assign remIn     = '0;
      assign accIn     = dividend;
      assign dvsIn     = divisor;
      assign sideStage = sideIn;
    end else begin : g_next
      assign remIn     = g_stage[s-1].remQ;
      assign accIn     = g_stage[s-1].accQ;
      assign dvsIn     = g_stage[s-1].dvsQ;
      assign sideStage = g_stage[s-1].sideQ;
    end
    always_ff @(posedge clk) begin
      {remQ, accQ} <= divStep(remIn, accIn, dvsIn);
      dvsQ         <= dvsIn;
      sideQ        <= sideStage;
    end
  end

  assign quotient = g_stage[STAGES-1].accQ;
  assign sideOut  = g_stage[STAGES-1].sideQ;

  // Final remainder must be below a nonzero divisor (R2 divide correctness).
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (g_stage[STAGES-1].dvsQ != '0) |-> (g_stage[STAGES-1].remQ < g_stage[STAGES-1].dvsQ));
endmodule

// File: rtl/ldq_control.sv
module ldq_control
  import ldq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int STAGES = 4,
  parameter int TIME_W = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic              deqReady,
  input  logic [TIME_W-1:0] headLateness,
  input  logic [TIME_W-1:0] cfgLateLimit,
  output ldqStrobes_t       strobes,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic              deqValid,
  output logic              tooLate
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [STAGES-1:0] validPipe;
  logic [CNT_W-1:0]  occ;   // stored plus in flight
  logic [CNT_W-1:0]  cnt;   // stored only
  logic              headDue;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    headDue        = ~headLateness[TIME_W-1];
    deqValid       = (cnt != '0) && headDue;
    strobes.launch = enqValid && (occ < CNT_W'(DEPTH));
    strobes.store  = validPipe[STAGES-1];
    strobes.pop    = deqValid && deqReady;
    tooLate        = deqValid && (headLateness > cfgLateLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validPipe <= '0;
      occ       <= '0;
      cnt       <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
    end else begin
      validPipe <= {validPipe[STAGES-2:0], strobes.launch};
      occ       <= occ + CNT_W'(strobes.launch) - CNT_W'(strobes.pop);
      cnt       <= cnt + CNT_W'(strobes.store) - CNT_W'(strobes.pop);
      if (strobes.store) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)   rdPtr <= nextPtr(rdPtr);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (occ <= CNT_W'(DEPTH)) && (cnt <= occ));

  assert_store_room_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.store |-> (cnt < CNT_W'(DEPTH)));

  assert_div_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.store |-> $past(strobes.launch, STAGES));

  assert_pop_removes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && !strobes.store) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ldq_datapath.sv
module ldq_datapath
  import ldq_pkg::*;
#(
  parameter int DESC_W = 72,
  parameter int TIME_W = 16,
  parameter int SIZE_W = 12,
  parameter int DEPTH  = 64,
  parameter int STAGES = 4,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldqStrobes_t       strobes,
  input  logic [DESC_W-1:0] enqDesc,
  input  logic [TIME_W-1:0] enqStamp,
  input  logic [SIZE_W-1:0] enqSize,
  input  logic [SIZE_W-1:0] cfgRate,
  input  logic [TIME_W-1:0] cfgBaseLatency,
  input  logic [TIME_W-1:0] simTime,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  output logic [DESC_W-1:0] deqDesc,
  output logic [TIME_W-1:0] headRelease,
  output logic [TIME_W-1:0] headLateness
);
  localparam int ENTRY_W = DESC_W + TIME_W;

  logic [SIZE_W-1:0]  divDividend, divDivisor, quotient;
  logic [ENTRY_W-1:0] sideIn, sideOut;
  logic [TIME_W-1:0]  relTime;
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ENTRY_W-1:0] headEntry;

  // Operand isolation: idle cycles push zeros through the divider.
  assign divDividend = strobes.launch ? enqSize : '0;
  assign divDivisor  = strobes.launch ? cfgRate : '0;
  assign sideIn      = strobes.launch ? {enqDesc, enqStamp + cfgBaseLatency} : '0;

  ldq_divider #(.W(SIZE_W), .STAGES(STAGES), .SIDE_W(ENTRY_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .dividend (divDividend),
    .divisor  (divDivisor),
    .sideIn   (sideIn),
    .quotient (quotient),
    .sideOut  (sideOut)
  );

  assign relTime = sideOut[TIME_W-1:0] + TIME_W'(quotient);

  always_ff @(posedge clk) begin
    if (strobes.store) mem[wrPtr] <= {sideOut[ENTRY_W-1:TIME_W], relTime};
  end

  assign headEntry    = mem[rdPtr];
  assign deqDesc      = headEntry[ENTRY_W-1:TIME_W];
  assign headRelease  = headEntry[TIME_W-1:0];
  assign headLateness = simTime - headRelease;
endmodule

// File: rtl/link_delay_queue.sv
module link_delay_queue
  import ldq_pkg::*;
#(
  parameter int DESC_W = 72,
  parameter int TIME_W = 16,
  parameter int SIZE_W = 12,
  parameter int DEPTH  = 64,
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [DESC_W-1:0] enqDesc,
  input  logic [TIME_W-1:0] enqStamp,
  input  logic [SIZE_W-1:0] enqSize,
  input  logic [SIZE_W-1:0] cfgRate,
  input  logic [TIME_W-1:0] cfgBaseLatency,
  input  logic [TIME_W-1:0] cfgLateLimit,
  input  logic [TIME_W-1:0] simTime,
  input  logic              deqReady,
  output logic              deqValid,
  output logic [DESC_W-1:0] deqDesc,
  output logic [TIME_W-1:0] headRelease,
  output logic              tooLate
);
  localparam int PTR_W = $clog2(DEPTH);

  ldqStrobes_t       strobes;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [TIME_W-1:0] headLateness;

  ldq_control #(.DEPTH(DEPTH), .STAGES(STAGES), .TIME_W(TIME_W), .PTR_W(PTR_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enqValid     (enqValid),
    .deqReady     (deqReady),
    .headLateness (headLateness),
    .cfgLateLimit (cfgLateLimit),
    .strobes      (strobes),
    .wrPtr        (wrPtr),
    .rdPtr        (rdPtr),
    .deqValid     (deqValid),
    .tooLate      (tooLate)
  );

  ldq_datapath #(.DESC_W(DESC_W), .TIME_W(TIME_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH),
                 .STAGES(STAGES), .PTR_W(PTR_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .enqDesc        (enqDesc),
    .enqStamp       (enqStamp),
    .enqSize        (enqSize),
    .cfgRate        (cfgRate),
    .cfgBaseLatency (cfgBaseLatency),
    .simTime        (simTime),
    .wrPtr          (wrPtr),
    .rdPtr          (rdPtr),
    .deqDesc        (deqDesc),
    .headRelease    (headRelease),
    .headLateness   (headLateness)
  );
endmodule

// File: tb/link_delay_queue_bench.sv
module link_delay_queue_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enqValid = 1'b0;
  logic [71:0] enqDesc = '0;
  logic [15:0] enqStamp = '0;
  logic [11:0] enqSize = '0;
  logic [11:0] cfgRate = 12'd1;
  logic [15:0] cfgBaseLatency = 16'd3;
  logic [15:0] cfgLateLimit = 16'hFFFF;
  logic [15:0] simTime = '0;
  logic        deqReady = 1'b0;
  logic        deqValid;
  logic [71:0] deqDesc;
  logic [15:0] headRelease;
  logic        tooLate;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  link_delay_queue u_link_delay_queue (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqDesc(enqDesc),
    .enqStamp(enqStamp), .enqSize(enqSize), .cfgRate(cfgRate),
    .cfgBaseLatency(cfgBaseLatency), .cfgLateLimit(cfgLateLimit),
    .simTime(simTime), .deqReady(deqReady), .deqValid(deqValid),
    .deqDesc(deqDesc), .headRelease(headRelease), .tooLate(tooLate)
  );

  // {stamp, size, rate, latency, expected release}
  localparam logic [71:0] VEC [8] = '{
    {16'h0010, 12'd100,  12'd10, 16'd3, 16'h001D},
    {16'h1000, 12'd4095, 12'd1,  16'd5, 16'h2004},
    {16'hFFF0, 12'd50,   12'd7,  16'd4, 16'hFFFB},
    {16'hFFF8, 12'd200,  12'd20, 16'd6, 16'h0008},  // R7 wrap
    {16'h2345, 12'd0,    12'd9,  16'd3, 16'h2348},
    {16'h0100, 12'd123,  12'd0,  16'd3, 16'h1102},  // R8 zero rate
    {16'h4000, 12'd1000, 12'd3,  16'd7, 16'h4154},
    {16'h7FFF, 12'd17,   12'd17, 16'd3, 16'h8003}
  };

  task automatic checkVal(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic enq(input logic [71:0] d, input logic [15:0] st, input logic [11:0] sz,
                     input logic [11:0] rt, input logic [15:0] lat);
    @(negedge clk);
    enqValid = 1'b1; enqDesc = d; enqStamp = st; enqSize = sz;
    cfgRate = rt; cfgBaseLatency = lat;
    @(negedge clk);
    enqValid = 1'b0;
  endtask

  task automatic popOne();
    @(negedge clk);
    deqReady = 1'b1;
    @(negedge clk);
    deqReady = 1'b0;
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    #1;
    checkVal("R1 deqValid after reset", 72'(deqValid), 72'(0));
    checkVal("R1 tooLate after reset", 72'(tooLate), 72'(0));
    rstN = 1'b1;
    @(negedge clk); #1;
    checkVal("R1 deqValid idle", 72'(deqValid), 72'(0));

    // Table walk: R2 release arithmetic, R7 wrap, R8 zero rate
    for (int i = 0; i < 8; i++) begin
      logic [71:0] d;
      logic [15:0] st, lat, exp;
      logic [11:0] sz, rt;
      {st, sz, rt, lat, exp} = VEC[i];
      d = {8'(i), 64'hC0DE_0000_1234_5600 + 64'(i)};
      @(negedge clk);
      simTime = st;
      enq(d, st, sz, rt, lat);
      repeat (6) @(negedge clk);
      #1;
      checkVal($sformatf("R2 release vec%0d", i), 72'(headRelease), 72'(exp));
      checkVal($sformatf("R7 not due at stamp vec%0d", i), 72'(deqValid), 72'(0));
      simTime = exp - 16'd1;
      #1;
      checkVal($sformatf("R7 not due one early vec%0d", i), 72'(deqValid), 72'(0));
      simTime = exp;
      #1;
      checkVal($sformatf("R7 due at release vec%0d", i), 72'(deqValid), 72'(1));
      checkVal($sformatf("R2 desc vec%0d", i), deqDesc, d);
      popOne();
      checkVal($sformatf("R9 empty after pop vec%0d", i), 72'(deqValid), 72'(0));
    end

    // R3: divider plus write latency, packet already due on arrival
    cfgLateLimit = 16'd2;
    simTime = 16'h0500;
    enq(72'hAB, 16'h0100, 12'd0, 12'd1, 16'd3);
    repeat (3) @(negedge clk);
    #1;
    checkVal("R3 not visible after E+3", 72'(deqValid), 72'(0));
    @(negedge clk); #1;
    checkVal("R3 visible after E+4", 72'(deqValid), 72'(1));
    checkVal("R6 late when lateness 0x3FD over 2", 72'(tooLate), 72'(1));
    popOne();

    // R4 order, R9 ignored deqReady, R6 late threshold
    simTime = 16'd0;
    enq(72'hA1, 16'd0, 12'd0, 12'd1, 16'd20);
    enq(72'hB2, 16'd0, 12'd0, 12'd1, 16'd3);
    repeat (6) @(negedge clk);
    simTime = 16'd5;
    #1;
    checkVal("R4 head blocks due follower", 72'(deqValid), 72'(0));
    checkVal("R4 head release", 72'(headRelease), 72'(20));
    @(negedge clk);
    deqReady = 1'b1;
    repeat (2) @(negedge clk);
    deqReady = 1'b0;
    #1;
    checkVal("R9 head kept after early deqReady", deqDesc, 72'hA1);
    checkVal("R9 release kept after early deqReady", 72'(headRelease), 72'(20));
    simTime = 16'd22;
    #1;
    checkVal("R6 due at limit", 72'(deqValid), 72'(1));
    checkVal("R6 not late at limit", 72'(tooLate), 72'(0));
    simTime = 16'd23;
    #1;
    checkVal("R6 late past limit", 72'(tooLate), 72'(1));
    popOne();
    checkVal("R4 second in order", deqDesc, 72'hB2);
    checkVal("R4 second due", 72'(deqValid), 72'(1));
    checkVal("R6 second late", 72'(tooLate), 72'(1));
    popOne();
    checkVal("R4 empty", 72'(deqValid), 72'(0));
    checkVal("R6 low when empty", 72'(tooLate), 72'(0));

    // R5 drop-tail: 66 back-to-back offers, 64 fit
    simTime = 16'd0;
    cfgRate = 12'd1; enqSize = '0; cfgBaseLatency = 16'd100; enqStamp = '0;
    for (int i = 0; i < 66; i++) begin
      @(negedge clk);
      enqValid = 1'b1;
      enqDesc = 72'(i);
    end
    @(negedge clk);
    enqValid = 1'b0;
    repeat (6) @(negedge clk);
    simTime = 16'd100;
    #1;
    for (int k = 0; k < 64; k++) begin
      checkVal($sformatf("R5 kept entry %0d valid", k), 72'(deqValid), 72'(1));
      checkVal($sformatf("R5 kept entry %0d desc", k), deqDesc, 72'(k));
      popOne();
    end
    checkVal("R5 overflow offers dropped", 72'(deqValid), 72'(0));

    finishRun();
  end
endmodule